// File: doc/BRIEF.md
# Interleaved Two-Pass CRC32 Device Serial Generator

This block builds a 64-bit device identifier from a 32-byte fuse shadow buffer. After a start pulse it reads sixteen bytes from the buffer through a simple synchronous read port. The bytes are read in an interleaved order: first the eight even-indexed bytes from 8 to 22, then the eight odd-indexed bytes from 7 to 21. It folds them one per clock through a bytewise CRC32.

The CRC register starts at zero and takes the first eight gathered bytes; its value at that point is the low word. The register is not reloaded and takes the last eight bytes, so the high word is a CRC seeded with the low word. Both words are published together with a valid flag. The flag stays high, and both words stay unchanged, until the next accepted start.

The buffer itself lives outside the block. Its read port must return the addressed byte one clock after the read enable and address are presented.

Top module: `serial_crc_gen`

## Requirements
- R1: While reset is held, and after it is released, `id_valid` is 0, `id_lo` and `id_hi` are 0, and `buf_rd_en` is 0.
- R2: A start accepted at clock edge E0 raises `buf_rd_en` on the cycles after edges E0 through E15, which is 16 consecutive reads. During the first eight of these, `buf_rd_addr` is 8, 10, 12, 14, 16, 18, 20, 22, in that order.
- R3: During the last eight reads, `buf_rd_addr` is 7, 9, 11, 13, 15, 17, 19, 21, in that order.
- R4: `id_lo` is the CRC32 of the first eight gathered bytes, taken in read order. The CRC uses reflected polynomial 0xEDB88320, a seed of 0, each byte fed LSB first, and no final inversion. An all-zero buffer therefore yields 0.
- R5: `id_hi` is the same CRC of the last eight gathered bytes, seeded with the value of `id_lo`.
- R6: `buf_rd_data` is sampled one clock after the read it answers is issued.
- R7: `id_valid` is 0 after edge E16 and 1 after edge E17, where E0 is the edge at which the start is accepted.
- R8: Once `id_valid` is 1, it stays 1 and `id_lo`/`id_hi` keep their values until the next accepted start.
- R9: A start pulse is accepted only when the block is idle. A start that arrives at any edge from E0 through E17 of a run is ignored and does not change that run's addresses, timing or result.
- R10: An accepted start clears `id_valid` after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to compute a new serial number |
| buf_rd_en | output | 1 | Shadow buffer read strobe |
| buf_rd_addr | output | 5 | Shadow buffer byte address |
| buf_rd_data | input | 8 | Byte returned one clock after the read strobe |
| id_lo | output | 32 | Low serial word |
| id_hi | output | 32 | High serial word |
| id_valid | output | 1 | Serial words are valid |

## Verification
The edge that accepts a start is counted as E0, and every check is placed against that count. The read address is sampled on the falling edge after each of E0 to E15 and compared with the interleaved index. `id_valid` is sampled after E16, when it must still be 0, and after E17, when it must be 1 and both words must equal a bit-serial model. One run injects a second start at E5 and expects identical timing and words. Another run waits ten cycles after completion to confirm that the words and the flag hold.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;
  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/crc32_byte_step.sv
module crc32_byte_step
  import serial_pkg::*;
#(
  parameter crc_t POLY = 32'hEDB88320
) (
  input  crc_t  crc_in,
  input  byte_t data_in,
  output crc_t  crc_out
);
  crc_t stage [0:BYTE_W];

  assign stage[0] = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, data_in};

  genvar b;
  generate
    for (b = 0; b < BYTE_W; b++) begin : g_bit
      assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
    end
  endgenerate

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/gather_seq.sv
module gather_seq #(
  parameter int BUF_DEPTH   = 32,
  parameter int HALF        = 8,
  parameter int FIRST_BASE  = 8,
  parameter int SECOND_BASE = 7,
  localparam int ADDR_W     = $clog2(BUF_DEPTH),
  localparam int GATHER     = 2 * HALF,
  localparam int IDX_W      = $clog2(GATHER + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              go,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  logic             busy;
  logic [IDX_W-1:0] idx;

  function automatic logic [ADDR_W-1:0] map_addr(input logic [IDX_W-1:0] k);
    int unsigned a;
    if (k < IDX_W'(HALF)) a = FIRST_BASE + 2 * int'(k);
    else                  a = SECOND_BASE + 2 * (int'(k) - HALF);
    return ADDR_W'(a);
  endfunction

  assign go = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      rd_en   <= 1'b1;
      rd_addr <= map_addr('0);
      idx     <= IDX_W'(1);
    end else if (busy) begin
      if (idx == IDX_W'(GATHER + 1)) begin
        busy <= 1'b0;
      end else if (idx == IDX_W'(GATHER)) begin
        rd_en <= 1'b0;
        idx   <= idx + 1'b1;
      end else begin
        rd_en   <= 1'b1;
        rd_addr <= map_addr(idx);
        idx     <= idx + 1'b1;
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && $past(rd_addr) != ADDR_W'(FIRST_BASE + 2*(HALF-1)))
      |-> rd_addr == $past(rd_addr) + ADDR_W'(2)); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && $past(rd_addr) == ADDR_W'(FIRST_BASE + 2*(HALF-1)))
      |-> rd_addr == ADDR_W'(SECOND_BASE)); // R3
  AST_READ_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(start)); // R2
  AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start && idx != IDX_W'(GATHER + 1)) |=> busy); // R9
endmodule

// File: rtl/crc_accum.sv
module crc_accum
  import serial_pkg::*;
#(
  parameter crc_t POLY = 32'hEDB88320,
  parameter int   HALF = 8,
  localparam int  GATHER = 2 * HALF,
  localparam int  CNT_W  = $clog2(GATHER + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  input  logic  dvalid,
  input  byte_t data,
  output crc_t  id_lo,
  output crc_t  id_hi,
  output logic  id_valid
);
  crc_t             crc_q, crc_nxt, lo_hold;
  logic [CNT_W-1:0] cnt;

  crc32_byte_step #(.POLY(POLY)) u_step (
    .crc_in (crc_q),
    .data_in(data),
    .crc_out(crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q    <= '0;
      lo_hold  <= '0;
      cnt      <= '0;
      id_lo    <= '0;
      id_hi    <= '0;
      id_valid <= 1'b0;
    end else if (go) begin
      crc_q    <= '0;
      cnt      <= '0;
      id_valid <= 1'b0;
    end else if (dvalid) begin
      crc_q <= crc_nxt;
      cnt   <= cnt + 1'b1;
      if (cnt == CNT_W'(HALF - 1)) lo_hold <= crc_nxt;
      if (cnt == CNT_W'(GATHER - 1)) begin
        id_lo    <= lo_hold;
        id_hi    <= crc_nxt;
        id_valid <= 1'b1;
      end
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (id_valid && !go) |=> id_valid); // R8
  AST_WORDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (id_valid && !go) |=> ($stable(id_lo) && $stable(id_hi))); // R8
  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    go |=> !id_valid); // R10
  AST_NO_EXTRA_BYTE: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> cnt < CNT_W'(GATHER)); // R2
endmodule

// File: rtl/serial_crc_gen.sv
module serial_crc_gen
  import serial_pkg::*;
#(
  parameter int   BUF_DEPTH = 32,
  parameter int   HALF      = 8,
  parameter crc_t POLY      = 32'hEDB88320,
  localparam int  ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_rd_addr,
  input  logic [7:0]        buf_rd_data,
  output logic [31:0]       id_lo,
  output logic [31:0]       id_hi,
  output logic              id_valid
);
  logic go;
  logic data_vld;

  gather_seq #(
    .BUF_DEPTH(BUF_DEPTH),
    .HALF     (HALF)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .go     (go),
    .rd_en  (buf_rd_en),
    .rd_addr(buf_rd_addr)
  );

  // one-cycle read latency of the shadow buffer
  always_ff @(posedge clk) begin
    if (rst) data_vld <= 1'b0;
    else     data_vld <= buf_rd_en;
  end

  crc_accum #(
    .POLY(POLY),
    .HALF(HALF)
  ) u_crc (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .dvalid  (data_vld),
    .data    (buf_rd_data),
    .id_lo   (id_lo),
    .id_hi   (id_hi),
    .id_valid(id_valid)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!id_valid && !buf_rd_en)); // R1
endmodule

// File: tb/serial_crc_gen_test.sv
module serial_crc_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        buf_rd_en;
  logic [4:0]  buf_rd_addr;
  logic [7:0]  buf_rd_data;
  logic [31:0] id_lo, id_hi;
  logic        id_valid;

  logic [7:0] mem [0:31];
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  int cap_n;
  logic [4:0] cap [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_crc_gen uut (
    .clk(clk), .rst(rst), .start(start),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .id_lo(id_lo), .id_hi(id_hi), .id_valid(id_valid)
  );

  // R6: buffer model with a one-clock registered read
  always @(posedge clk) if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];

  always @(negedge clk) if (buf_rd_en && cap_n < 32) begin
    cap[cap_n] = buf_rd_addr;
    cap_n = cap_n + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc(input logic [31:0] seed, input int first);
    logic [31:0] c = seed;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      int gi = first + i;
      d = (gi < 8) ? mem[8 + 2*gi] : mem[7 + 2*(gi - 8)];
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ d[b];
        c = c >> 1;
        if (fb) c = c ^ POLY;
      end
    end
    return c;
  endfunction

  task automatic run(input bit extra_start);
    logic [31:0] elo, ehi;
    elo = model_crc(32'h0, 0);
    ehi = model_crc(elo, 8);
    cap_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;          // after E0
    chk("R10 valid cleared", {63'b0, id_valid}, 64'd0);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      start = (extra_start && k == 4);      // seen at E5: R9
    end
    start = 1'b0;
    chk("R7 valid low after E16", {63'b0, id_valid}, 64'd0);
    @(negedge clk);                        // after E17
    chk("R7 valid high after E17", {63'b0, id_valid}, 64'd1);
    chk("R2 R6 read count", 64'(cap_n), 64'd16);
    for (int i = 0; i < 8; i++) begin
      chk("R2 first-half address", {59'b0, cap[i]}, 64'(8 + 2*i));
      chk("R3 second-half address", {59'b0, cap[i+8]}, 64'(7 + 2*i));
    end
    chk("R4 low word", {32'b0, id_lo}, {32'b0, elo});
    chk("R5 high word", {32'b0, id_hi}, {32'b0, ehi});
    if (extra_start) chk("R9 busy start ignored", {63'b0, id_valid}, 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {63'b0, id_valid}, 64'd0);
    chk("R1 words in reset", {id_hi, id_lo}, 64'd0);
    chk("R1 no read in reset", {63'b0, buf_rd_en}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {63'b0, id_valid}, 64'd0);

    run(1'b0);                               // R4 all-zero buffer
    chk("R4 zero buffer gives zero", {id_hi, id_lo}, 64'd0);

    for (int i = 0; i < 32; i++) mem[i] = 8'hFF;
    run(1'b0);

    for (int i = 0; i < 32; i++) mem[i] = 8'(i);  // only gathered bytes matter
    run(1'b0);

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 32; i++) mem[i] = 8'($urandom);
      run(t == 3);
      if (t == 5) begin
        logic [63:0] held;
        held = {id_hi, id_lo};
        for (int i = 0; i < 32; i++) mem[i] = ~mem[i];
        repeat (10) @(negedge clk);
        chk("R8 valid held", {63'b0, id_valid}, 64'd1);
        chk("R8 words held", {id_hi, id_lo}, held);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule